// File: doc/BRIEF.md
# UART Interrupt Status and Routing

This block is the interrupt section of a UART. Eleven event sources feed it set pulses: the receive and transmit FIFO logic, the receive timeout counter, the modem-status inputs and the line error detectors. The block stores each event in a raw status register. A software-written enable register gates the raw status. The block drives six interrupt lines: one combined line that ORs every source, and five lines that each cover one group of sources.

Software reaches the block through a small register bus. The bus has a write strobe, a word address and a write data word, and read data returns combinationally from the address. Software can read the raw status, the enabled (masked) status and the enable register. It acknowledges events by writing ones to a clear register. A write to the transmit data address also raises the transmit event inside the block, so the transmit interrupt is pending in the same clock as the write.

Status bits, in the order the grouping depends on:

- Modem group:
  - bit 0: ring
  - bit 1: clear-to-send
  - bit 2: carrier detect
  - bit 3: data-set-ready
- Receive: bit 4.
- Transmit: bit 5.
- Receive timeout: bit 6.
- Error group:
  - bit 7: framing
  - bit 8: parity
  - bit 9: break
  - bit 10: overrun

Word addresses on the bus:

| Address | Register |
|---------|----------|
| 0 | transmit data |
| 1 | enable |
| 2 | raw status |
| 3 | masked status |
| 4 | clear |

Top module: `uirq_ctrl`

## Requirements
- R1: After reset the enable register and the raw status read as zero, and all six interrupt outputs are low.
- R2: A read at address 2 returns the 11 raw status bits in bits 10:0 of the read data. Bits 31:11 read as zero.
- R3: A read at address 3 returns the raw status ANDed with the enable register.
- R4: Bus writes to address 2 or address 3 change neither the raw status nor the enable register.
- R5: A write to address 4 clears every raw bit whose write data bit is 1 and leaves all other raw bits unchanged. A read at address 4 returns zero.
- R6: A pulse on event input bit n sets raw bit n at the next clock edge. If a set and a clear hit the same bit in the same cycle, the set wins.
- R7: A bus write to address 0 sets raw bit 5 (transmit) at the same clock edge as the write.
- R8: Each of the five group outputs is high exactly when the masked status has a bit set in its group. The groups are:
  - receive line: bit 4
  - transmit line: bit 5
  - timeout line: bit 6
  - modem line: bits 3:0
  - error line: bits 10:7
- R9: The combined output is high exactly when any bit 10:0 of the masked status is set.
- R10: The outputs are registered. They reflect an enable write, a clear write or an event at the same clock edge that updates the status, which is one clock after the write or event is presented.
- R11: A write to address 1 loads bits 10:0 into the enable register. A read at address 1 returns them, with bits 31:11 as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational from address) |
| evt_set | input | 11 | One-cycle set pulses, one per status bit |
| irq_all | output | 1 | Combined interrupt |
| irq_rx | output | 1 | Receive interrupt |
| irq_tx | output | 1 | Transmit interrupt |
| irq_rt | output | 1 | Receive-timeout interrupt |
| irq_ms | output | 1 | Modem-status interrupt |
| irq_err | output | 1 | Error interrupt |

## Verification
The routing test walks a single event through each of the eleven status bits with every enable set. This distinguishes a bit landing in the wrong group from a bit that reaches no line at all. Partial enable patterns check that a pending but disabled bit shows in the raw view but not in the masked view or on any line. Clear tests compare a subset clear with a clear that collides with a new event in the same cycle, which exposes the set-over-clear priority. Writes to the read-only views and the transmit data write are checked through readback, so stray write decoding shows up at the ports.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int STAT_W = 11;
  localparam int NGRP   = 5;
  localparam int ADDR_W = 3;

  // status bit positions
  localparam int B_RING = 0;
  localparam int B_CTS  = 1;
  localparam int B_DCD  = 2;
  localparam int B_DSR  = 3;
  localparam int B_RX   = 4;
  localparam int B_TX   = 5;
  localparam int B_RT   = 6;
  localparam int B_FE   = 7;
  localparam int B_PE   = 8;
  localparam int B_BE   = 9;
  localparam int B_OE   = 10;

  // group index order of the separate outputs
  localparam int G_RX  = 0;
  localparam int G_TX  = 1;
  localparam int G_RT  = 2;
  localparam int G_MS  = 3;
  localparam int G_ERR = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_TXDATA = 3'd0,
    A_ENABLE = 3'd1,
    A_RAW    = 3'd2,
    A_MASKED = 3'd3,
    A_CLEAR  = 3'd4
  } reg_addr_e;

  typedef logic [STAT_W-1:0] stat_t;

  // bits belonging to one output group
  function automatic stat_t grp_mask(input int g);
    stat_t m;
    m = '0;
    case (g)
      G_RX:    m[B_RX] = 1'b1;
      G_TX:    m[B_TX] = 1'b1;
      G_RT:    m[B_RT] = 1'b1;
      G_MS:    for (int b = B_RING; b <= B_DSR; b++) m[b] = 1'b1;
      G_ERR:   for (int b = B_FE; b <= B_OE; b++) m[b] = 1'b1;
      default: m = '0;
    endcase
    return m;
  endfunction

  // union of all groups, the combined line's coverage
  function automatic stat_t all_groups();
    stat_t m;
    m = '0;
    for (int g = 0; g < NGRP; g++) m = m | grp_mask(g);
    return m;
  endfunction

  // next raw status: clear first, then sets win
  function automatic stat_t raw_next(input stat_t raw, input stat_t clr, input stat_t set);
    return (raw & ~clr) | set;
  endfunction
endpackage

// File: rtl/uirq_regs.sv
module uirq_regs
  import uirq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  stat_t             evt_set,
  output logic [DATA_W-1:0] bus_rdata,
  output stat_t             raw_q,
  output stat_t             mask_q,
  output stat_t             raw_d,
  output stat_t             mask_d
);
  localparam int PAD_W = DATA_W - STAT_W;

  // named decode events
  logic  wr_enable, wr_clear, wr_txdata;
  stat_t clr_vec, set_vec, wdata_s;

  assign wdata_s   = bus_wdata[STAT_W-1:0];
  assign wr_enable = bus_wr && (bus_addr == A_ENABLE);
  assign wr_clear  = bus_wr && (bus_addr == A_CLEAR);
  assign wr_txdata = bus_wr && (bus_addr == A_TXDATA);

  always_comb begin
    set_vec = evt_set;
    if (wr_txdata) set_vec[B_TX] = 1'b1;
    clr_vec = wr_clear ? wdata_s : '0;
  end

  assign raw_d  = raw_next(raw_q, clr_vec, set_vec);
  assign mask_d = wr_enable ? wdata_s : mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q  <= raw_d;
      mask_q <= mask_d;
    end
  end

  always_comb begin
    case (bus_addr)
      A_ENABLE: bus_rdata = {{PAD_W{1'b0}}, mask_q};
      A_RAW:    bus_rdata = {{PAD_W{1'b0}}, raw_q};
      A_MASKED: bus_rdata = {{PAD_W{1'b0}}, raw_q & mask_q};
      default:  bus_rdata = '0;
    endcase
  end

  // R6: a set pulse is visible in the raw status after the edge
  p_set_sticks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((raw_q & $past(set_vec)) == $past(set_vec)));

  // R5: cleared bits without a concurrent set are zero afterwards
  p_clear_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clear |=> ((raw_q & $past(wdata_s) & ~$past(set_vec)) == '0));

  // R4: writes to read-only views touch no state
  p_ro_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr == A_RAW || bus_addr == A_MASKED) && evt_set == '0)
      |=> ($stable(raw_q) && $stable(mask_q)));

  // R7: data write raises the transmit bit
  p_tx_on_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_txdata |=> raw_q[B_TX]);
endmodule

// File: rtl/uirq_route.sv
module uirq_route
  import uirq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  stat_t           raw_d,
  input  stat_t           mask_d,
  output logic [NGRP-1:0] grp_irq,
  output logic            comb_irq
);
  localparam stat_t ALL_M = all_groups();

  stat_t masked_d;
  assign masked_d = raw_d & mask_d;

  for (genvar g = 0; g < NGRP; g++) begin : g_line
    localparam stat_t GM = grp_mask(g);
    always_ff @(posedge clk) begin
      if (!rst_n) grp_irq[g] <= 1'b0;
      else        grp_irq[g] <= |(masked_d & GM);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) comb_irq <= 1'b0;
    else        comb_irq <= |(masked_d & ALL_M);
  end

  // R9: the combined line agrees with the separate lines
  p_comb_matches_r9: assert property (@(posedge clk) disable iff (!rst_n)
    comb_irq == (|grp_irq));
endmodule

// File: rtl/uirq_ctrl.sv
module uirq_ctrl
  import uirq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [10:0] evt_set,
  output logic        irq_all,
  output logic        irq_rx,
  output logic        irq_tx,
  output logic        irq_rt,
  output logic        irq_ms,
  output logic        irq_err
);
  stat_t           raw_q, mask_q, raw_d, mask_d;
  logic [NGRP-1:0] grp_irq;

  uirq_regs #(.DATA_W(32)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .evt_set   (evt_set),
    .bus_rdata (bus_rdata),
    .raw_q     (raw_q),
    .mask_q    (mask_q),
    .raw_d     (raw_d),
    .mask_d    (mask_d)
  );

  uirq_route u_route (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw_d    (raw_d),
    .mask_d   (mask_d),
    .grp_irq  (grp_irq),
    .comb_irq (irq_all)
  );

  assign irq_rx  = grp_irq[G_RX];
  assign irq_tx  = grp_irq[G_TX];
  assign irq_rt  = grp_irq[G_RT];
  assign irq_ms  = grp_irq[G_MS];
  assign irq_err = grp_irq[G_ERR];

  // R8: every line tracks its group of the stored masked status
  p_lines_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_rx  == |(raw_q & mask_q & grp_mask(G_RX)))  &&
    (irq_tx  == |(raw_q & mask_q & grp_mask(G_TX)))  &&
    (irq_rt  == |(raw_q & mask_q & grp_mask(G_RT)))  &&
    (irq_ms  == |(raw_q & mask_q & grp_mask(G_MS)))  &&
    (irq_err == |(raw_q & mask_q & grp_mask(G_ERR))));
endmodule

// File: tb/uirq_ctrl_tb.sv
module uirq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [10:0] evt_set = '0;
  logic        irq_all, irq_rx, irq_tx, irq_rt, irq_ms, irq_err;

  int n_chk = 0;
  int n_bad = 0;

  // bench-side model
  logic [10:0] m_raw = '0;
  logic [10:0] m_en  = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uirq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_set(evt_set),
    .irq_all(irq_all), .irq_rx(irq_rx), .irq_tx(irq_tx), .irq_rt(irq_rt),
    .irq_ms(irq_ms), .irq_err(irq_err)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // expected line vector {all, err, ms, rt, tx, rx}
  function automatic logic [5:0] exp_lines(input logic [10:0] r, input logic [10:0] e);
    logic [10:0] m;
    m = r & e;
    return {|m, |m[10:7], |m[3:0], m[6], m[5], m[4]};
  endfunction

  task automatic chk_lines(input string req);
    chk(req, {26'd0, irq_all, irq_err, irq_ms, irq_rt, irq_tx, irq_rx},
        {26'd0, exp_lines(m_raw, m_en)});
  endtask

  // one clock: drive at negedge, update model, sample at following negedge
  task automatic step(input logic wr, input logic [2:0] a, input logic [31:0] d,
                      input logic [10:0] e);
    logic [10:0] set;
    bus_wr = wr; bus_addr = a; bus_wdata = d; evt_set = e;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0; evt_set = '0;
    set = e;
    if (wr && a == 3'd0) set[5] = 1'b1;
    if (wr && a == 3'd1) m_en = d[10:0];
    if (wr && a == 3'd4) m_raw = m_raw & ~d[10:0];
    m_raw = m_raw | set;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(3'd1, v); chk("R1 enable", v, 32'd0);
    rd(3'd2, v); chk("R1 raw", v, 32'd0);
    chk_lines("R1 lines");
  endtask

  task automatic t_events();
    logic [31:0] v;
    step(1'b0, 3'd2, 32'd0, 11'h481);
    rd(3'd2, v); chk("R6 event set", v, {21'd0, m_raw});
    chk("R2 raw value", v, 32'h0000_0481);
    chk_lines("R10 disabled bits give no line");
  endtask

  task automatic t_enable();
    logic [31:0] v;
    step(1'b1, 3'd1, 32'hFFFF_F401, 11'h0);
    rd(3'd1, v); chk("R11 enable readback", v, 32'h0000_0401);
    rd(3'd3, v); chk("R3 masked read", v, {21'd0, m_raw & m_en});
    chk_lines("R10 lines after enable write");
    chk("R9 combined up", {31'd0, irq_all}, 32'd1);
  endtask

  task automatic t_ignore();
    logic [31:0] v;
    step(1'b1, 3'd2, 32'h0000_07FF, 11'h0);
    step(1'b1, 3'd3, 32'h0000_0000, 11'h0);
    rd(3'd2, v); chk("R4 raw unchanged", v, 32'h0000_0481);
    rd(3'd1, v); chk("R4 enable unchanged", v, 32'h0000_0401);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    step(1'b1, 3'd4, 32'h0000_0400, 11'h0);
    rd(3'd2, v); chk("R5 subset clear", v, 32'h0000_0081);
    chk_lines("R10 lines after clear");
    rd(3'd4, v); chk("R5 clear reads zero", v, 32'd0);
    step(1'b1, 3'd4, 32'h0000_0001, 11'h001);
    rd(3'd2, v); chk("R6 set beats clear", v, 32'h0000_0081);
    step(1'b1, 3'd4, 32'h0000_07FF, 11'h0);
    rd(3'd2, v); chk("R5 clear all", v, 32'd0);
  endtask

  task automatic t_txwrite();
    logic [31:0] v;
    step(1'b1, 3'd1, 32'h0000_0020, 11'h0);
    step(1'b1, 3'd0, 32'h0000_0041, 11'h0);
    rd(3'd2, v); chk("R7 tx bit on data write", v, 32'h0000_0020);
    chk("R7 tx line", {31'd0, irq_tx}, 32'd1);
    step(1'b1, 3'd4, 32'h0000_0020, 11'h0);
  endtask

  task automatic t_groups();
    step(1'b1, 3'd1, 32'h0000_07FF, 11'h0);
    for (int b = 0; b < 11; b++) begin
      step(1'b0, 3'd2, 32'd0, 11'd1 << b);
      chk_lines($sformatf("R8 routing bit %0d", b));
      chk("R9 combined", {31'd0, irq_all}, 32'd1);
      step(1'b1, 3'd4, 32'h0000_07FF, 11'h0);
      chk_lines($sformatf("R8 cleared bit %0d", b));
    end
    step(1'b1, 3'd1, 32'h0000_0000, 11'h0);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_events();
    t_enable();
    t_ignore();
    t_clear();
    t_txwrite();
    t_groups();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule